// File: doc/BRIEF.md
# Request Latency and Sequence Bandwidth Monitor

This block watches a request/response memory interface that tags every request with a transaction ID. When a request is accepted, the block stores a timestamp from a free-running cycle counter in a table indexed by the ID. When the response with that ID returns, it computes the latency in clock cycles. From these latencies it keeps a minimum and a maximum, each with the ID of the transaction that produced it, plus a running latency sum and a response count. Software reads the sum and the count and divides them to get the average.

A start pulse opens a measurement sequence. It clears the statistics and begins counting clock cycles. The count stops when a response leaves no request outstanding, so the final value is the number of cycles the sequence occupied, which is the bandwidth figure. While requests are outstanding, the block compares their age against a programmable limit. A sticky timeout flag is raised when the oldest one exceeds that limit.

Top module: `lat_bw_mon`

## Requirements
- R1: After reset, the minimum latency is all ones, the maximum latency, both IDs, the sum, the count and the cycle count are zero, and the busy and timeout flags are low.
- R2: A response is taken at clock edge b for an ID whose request was taken at edge a. Its latency is b-a cycles. At the next output update, the sum grows by that latency and the count grows by one.
- R3: A latency strictly below the stored minimum replaces it and records the response ID. An equal latency leaves the minimum and its ID unchanged.
- R4: A latency strictly above the stored maximum replaces it and records the response ID. An equal latency leaves the maximum and its ID unchanged.
- R5: A response whose ID has no outstanding request leaves every statistic unchanged.
- R6: A start pulse resets the minimum to all ones, and resets the maximum, both IDs, the sum, the count and the cycle count to zero. It also sets the busy flag.
- R7: Take a start at edge s and, at edge e, a response that leaves no request outstanding. The cycle count then reads e-s and busy goes low. The count stays frozen until the next start.
- R8: With a non-zero limit L, a request outstanding since edge a sets the timeout flag at edge a+L+1. A limit of zero never sets it.
- R9: The timeout flag stays set until tmo_clr_i is high at an edge where no outstanding request exceeds the limit. While the condition still holds, the clear is overridden.
- R10: All 16 IDs are tracked independently, and responses may return in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sequence start pulse, clears statistics |
| req_valid_i | input | 1 | Request accepted this cycle |
| req_id_i | input | 4 | Request transaction ID |
| rsp_valid_i | input | 1 | Response returned this cycle |
| rsp_id_i | input | 4 | Response transaction ID |
| tmo_limit_i | input | 16 | Timeout limit in cycles, 0 disables |
| tmo_clr_i | input | 1 | Clear request for the timeout flag |
| min_lat_o | output | 16 | Minimum latency |
| min_id_o | output | 4 | ID that produced the minimum |
| max_lat_o | output | 16 | Maximum latency |
| max_id_o | output | 4 | ID that produced the maximum |
| lat_sum_o | output | 32 | Accumulated latency |
| rsp_cnt_o | output | 24 | Counted responses |
| seq_cycles_o | output | 24 | Cycles taken by the current or last sequence |
| seq_busy_o | output | 1 | Sequence running |
| tmo_o | output | 1 | Sticky timeout flag |

## Verification
A corrupted timestamp entry or pending bit shows up at the response one cycle later, as a wrong sum step, a missing count increment or a misplaced minimum or maximum. A stale pending bit also shows as a timeout flag that rises early, or a busy flag that never drops. The bench keeps an arithmetic model of every ID's request edge and compares all outputs after every cycle. A fault therefore surfaces in the first cycle after the response or the age crossing that exposes it.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/lat_ts_table.sv
module lat_ts_table #(
  parameter int ID_W = 4,
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] now_i,
  input  logic            req_valid_i,
  input  logic [ID_W-1:0] req_id_i,
  input  logic            rsp_valid_i,
  input  logic [ID_W-1:0] rsp_id_i,
  input  logic [TS_W-1:0] tmo_limit_i,
  output logic            rsp_hit_o,
  output logic [TS_W-1:0] rsp_lat_o,
  output logic            idle_next_o,
  output logic            tmo_hit_o
);
  localparam int DEPTH = 1 << ID_W;

  logic [TS_W-1:0]  ts_q [DEPTH];
  logic [DEPTH-1:0] pend_q, pend_d, over;

  assign rsp_hit_o = rsp_valid_i && pend_q[rsp_id_i];
  assign rsp_lat_o = now_i - ts_q[rsp_id_i];

  always_comb begin
    pend_d = pend_q;
    if (rsp_hit_o)   pend_d[rsp_id_i] = 1'b0;
    if (req_valid_i) pend_d[req_id_i] = 1'b1;
  end

  assign idle_next_o = (pend_d == '0);

  // any pending entry past the limit implies the oldest one is
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [TS_W-1:0] age;
    assign age     = now_i - ts_q[g];
    assign over[g] = pend_q[g] && (age > tmo_limit_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ts_q[g] <= '0;
      else if (req_valid_i && req_id_i == ID_W'(g))     ts_q[g] <= now_i;
    end
  end

  assign tmo_hit_o = (tmo_limit_i != '0) && (over != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end
endmodule

// File: rtl/lat_stats.sv
module lat_stats #(
  parameter int ID_W  = 4,
  parameter int TS_W  = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [TS_W-1:0]  lat_i,
  input  logic [ID_W-1:0]  id_i,
  output logic [TS_W-1:0]  min_lat_o,
  output logic [ID_W-1:0]  min_id_o,
  output logic [TS_W-1:0]  max_lat_o,
  output logic [ID_W-1:0]  max_id_o,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_lat_o <= '1;
      min_id_o  <= '0;
      max_lat_o <= '0;
      max_id_o  <= '0;
      sum_o     <= '0;
      cnt_o     <= '0;
    end else if (clear_i) begin
      min_lat_o <= '1;
      min_id_o  <= '0;
      max_lat_o <= '0;
      max_id_o  <= '0;
      sum_o     <= '0;
      cnt_o     <= '0;
    end else if (upd_i) begin
      if (lat_i < min_lat_o) begin
        min_lat_o <= lat_i;
        min_id_o  <= id_i;
      end
      if (lat_i > max_lat_o) begin
        max_lat_o <= lat_i;
        max_id_o  <= id_i;
      end
      sum_o <= sum_o + SUM_W'(lat_i);
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/lat_seq_timer.sv
module lat_seq_timer
  import lat_mon_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             tmo_hit_i,
  input  logic             tmo_clr_i,
  output logic [CNT_W-1:0] cycles_o,
  output logic             busy_o,
  output logic             tmo_o
);
  seq_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SEQ_IDLE;
      cycles_o <= '0;
    end else if (start_i) begin
      st_q     <= SEQ_RUN;
      cycles_o <= '0;
    end else if (st_q == SEQ_RUN) begin
      cycles_o <= cycles_o + 1'b1;
      if (done_i) st_q <= SEQ_IDLE;
    end
  end

  assign busy_o = (st_q == SEQ_RUN);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmo_o <= 1'b0;
    else if (tmo_hit_i) tmo_o <= 1'b1;
    else if (tmo_clr_i) tmo_o <= 1'b0;
  end
endmodule

// File: rtl/lat_bw_mon.sv
module lat_bw_mon #(
  parameter int ID_W  = 4,
  parameter int TS_W  = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             req_valid_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             rsp_valid_i,
  input  logic [ID_W-1:0]  rsp_id_i,
  input  logic [TS_W-1:0]  tmo_limit_i,
  input  logic             tmo_clr_i,
  output logic [TS_W-1:0]  min_lat_o,
  output logic [ID_W-1:0]  min_id_o,
  output logic [TS_W-1:0]  max_lat_o,
  output logic [ID_W-1:0]  max_id_o,
  output logic [SUM_W-1:0] lat_sum_o,
  output logic [CNT_W-1:0] rsp_cnt_o,
  output logic [CNT_W-1:0] seq_cycles_o,
  output logic             seq_busy_o,
  output logic             tmo_o
);
  logic [TS_W-1:0] now_q, rsp_lat;
  logic            rsp_hit, idle_next, tmo_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  lat_ts_table #(.ID_W(ID_W), .TS_W(TS_W)) u_table (
    .clk_i, .rst_ni,
    .now_i       (now_q),
    .req_valid_i, .req_id_i,
    .rsp_valid_i, .rsp_id_i,
    .tmo_limit_i,
    .rsp_hit_o   (rsp_hit),
    .rsp_lat_o   (rsp_lat),
    .idle_next_o (idle_next),
    .tmo_hit_o   (tmo_hit)
  );

  lat_stats #(.ID_W(ID_W), .TS_W(TS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni,
    .clear_i   (start_i),
    .upd_i     (rsp_hit),
    .lat_i     (rsp_lat),
    .id_i      (rsp_id_i),
    .min_lat_o, .min_id_o, .max_lat_o, .max_id_o,
    .sum_o     (lat_sum_o),
    .cnt_o     (rsp_cnt_o)
  );

  lat_seq_timer #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .done_i    (rsp_hit && idle_next),
    .tmo_hit_i (tmo_hit),
    .tmo_clr_i,
    .cycles_o  (seq_cycles_o),
    .busy_o    (seq_busy_o),
    .tmo_o
  );
endmodule

// File: rtl/lat_bw_mon_chk.sv
module lat_bw_mon_chk #(
  parameter int ID_W  = 4,
  parameter int TS_W  = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             tmo_clr_i,
  input logic [TS_W-1:0]  min_lat_o,
  input logic [TS_W-1:0]  max_lat_o,
  input logic [CNT_W-1:0] rsp_cnt_o,
  input logic [CNT_W-1:0] seq_cycles_o,
  input logic             seq_busy_o,
  input logic             tmo_o
);
  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (rsp_cnt_o == $past(rsp_cnt_o)) || (rsp_cnt_o == $past(rsp_cnt_o) + 1'b1));

  a_r2_min_le_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_cnt_o != '0) |-> (min_lat_o <= max_lat_o));

  a_r3_min_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> min_lat_o <= $past(min_lat_o));

  a_r4_max_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> max_lat_o >= $past(max_lat_o));

  a_r6_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (rsp_cnt_o == '0) && (seq_cycles_o == '0) && seq_busy_o && (max_lat_o == '0));

  a_r7_seq_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_busy_o && !start_i) |=> $stable(seq_cycles_o));

  a_r9_tmo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !tmo_clr_i) |=> tmo_o);
endmodule

bind lat_bw_mon lat_bw_mon_chk #(.ID_W(ID_W), .TS_W(TS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/lat_bw_mon_bench.sv
`timescale 1ns/1ps
module lat_bw_mon_bench;
  logic        clk_i = 0, rst_ni = 0;
  logic        start_i = 0, req_valid_i = 0, rsp_valid_i = 0, tmo_clr_i = 0;
  logic [3:0]  req_id_i = 0, rsp_id_i = 0;
  logic [15:0] tmo_limit_i = 0;
  logic [15:0] min_lat_o, max_lat_o;
  logic [3:0]  min_id_o, max_id_o;
  logic [31:0] lat_sum_o;
  logic [23:0] rsp_cnt_o, seq_cycles_o;
  logic        seq_busy_o, tmo_o;

  always #4 clk_i = ~clk_i;

  lat_bw_mon u_lat_bw_mon (.*);

  int vecs = 0, errs = 0;
  int ts_m[16];
  bit pend_m[16];
  int min_m = 16'hFFFF, max_m = 0, min_id_m = 0, max_id_m = 0, sum_m = 0, cnt_m = 0;
  int seq_m = 0, start_e = 0, edge_n = 0;
  bit busy_m = 0, tmo_m = 0;

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R3 min_lat", int'(min_lat_o), min_m);
    chk("R3 min_id", int'(min_id_o), min_id_m);
    chk("R4 max_lat", int'(max_lat_o), max_m);
    chk("R4 max_id", int'(max_id_o), max_id_m);
    chk("R2 lat_sum", int'(lat_sum_o), sum_m);
    chk("R2 rsp_cnt", int'(rsp_cnt_o), cnt_m);
    chk("R7 seq_cycles", int'(seq_cycles_o), seq_m);
    chk("R7 seq_busy", int'(seq_busy_o), int'(busy_m));
    chk("R8 tmo", int'(tmo_o), int'(tmo_m));
  endtask

  task automatic step(bit rv, int ri, bit sv, int si, bit st, bit clr);
    bit cond, hit, any;
    req_valid_i = rv; req_id_i = 4'(ri);
    rsp_valid_i = sv; rsp_id_i = 4'(si);
    start_i = st;     tmo_clr_i = clr;
    @(posedge clk_i);
    cond = 0;
    if (tmo_limit_i != 0)
      for (int i = 0; i < 16; i++)
        if (pend_m[i] && (edge_n - ts_m[i]) > int'(tmo_limit_i)) cond = 1;
    hit = sv && pend_m[si];
    if (st) begin
      min_m = 16'hFFFF; max_m = 0; min_id_m = 0; max_id_m = 0; sum_m = 0; cnt_m = 0;
    end else if (hit) begin
      int lat = edge_n - ts_m[si];
      if (lat < min_m) begin min_m = lat; min_id_m = si; end
      if (lat > max_m) begin max_m = lat; max_id_m = si; end
      sum_m += lat; cnt_m++;
    end
    if (hit) pend_m[si] = 0;
    if (rv) begin ts_m[ri] = edge_n; pend_m[ri] = 1; end
    any = 0;
    for (int i = 0; i < 16; i++) if (pend_m[i]) any = 1;
    if (st) begin busy_m = 1; start_e = edge_n; seq_m = 0; end
    else if (busy_m) begin
      seq_m = edge_n - start_e;
      if (hit && !any) busy_m = 0;
    end
    tmo_m = cond ? 1'b1 : (clr ? 1'b0 : tmo_m);
    edge_n++;
    @(negedge clk_i);
    req_valid_i = 0; rsp_valid_i = 0; start_i = 0; tmo_clr_i = 0;
    cmp_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog R1..: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin ts_m[i] = 0; pend_m[i] = 0; end
    #20;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 min_lat", int'(min_lat_o), 16'hFFFF);
    chk("R1 max_lat", int'(max_lat_o), 0);
    chk("R1 rsp_cnt", int'(rsp_cnt_o), 0);
    chk("R1 seq_busy", int'(seq_busy_o), 0);
    chk("R1 tmo", int'(tmo_o), 0);
    rst_ni = 1;

    // R2 latency sweep 1..20 with R7 sequence count
    step(0, 0, 0, 0, 1, 0);
    for (int l = 1; l <= 20; l++) begin
      step(1, l % 16, 0, 0, 0, 0);
      idle(l - 1);
      step(0, 0, 1, l % 16, 0, 0);
      idle(2);
    end

    // R6 restart, R10 all IDs out of order
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) step(1, i, 0, 0, 0, 0);
    for (int i = 15; i >= 0; i--) step(0, 0, 1, i, 0, 0);
    idle(3);
    for (int i = 0; i < 16; i++) begin
      step(1, i, 0, 0, 0, 0);
      if (i % 2) step(0, 0, 1, i - 1, 0, 0);
    end
    for (int i = 15; i > 0; i -= 2) begin idle(i % 3); step(0, 0, 1, i, 0, 0); end

    // R3 R4 ties keep the first ID
    step(0, 0, 0, 0, 1, 0);
    step(1, 3, 0, 0, 0, 0);
    step(1, 5, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 1, 3, 0, 0);
    step(0, 0, 1, 5, 0, 0);
    chk("R3 tie min_id", int'(min_id_o), 3);
    chk("R4 tie max_id", int'(max_id_o), 3);

    // R5 responses with nothing outstanding
    step(0, 0, 1, 9, 0, 0);
    step(0, 0, 1, 3, 0, 0);
    chk("R5 cnt unchanged", int'(rsp_cnt_o), 2);

    // R8 R9 timeout
    tmo_limit_i = 5;
    step(1, 7, 0, 0, 0, 0);
    idle(8);
    chk("R8 tmo set", int'(tmo_o), 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 clear overridden", int'(tmo_o), 1);
    step(0, 0, 1, 7, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 cleared", int'(tmo_o), 0);
    idle(3);
    for (int l = 1; l <= 4; l++) begin
      tmo_limit_i = 16'(l);
      step(1, l, 0, 0, 0, 0);
      idle(l + 2);
      step(0, 0, 1, l, 0, 0);
      step(0, 0, 0, 0, 0, 1);
    end
    tmo_limit_i = 0;
    step(1, 2, 0, 0, 0, 0);
    idle(30);
    chk("R8 limit zero", int'(tmo_o), 0);
    step(0, 0, 1, 2, 0, 0);

    // R7 start with no traffic keeps counting
    step(0, 0, 0, 0, 1, 0);
    idle(10);
    chk("R7 seq running", int'(seq_cycles_o), 10);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule